// File: doc/BRIEF.md
# Dual-Window Processor Mailbox

This block links a host CPU and an audio coprocessor through four byte-wide mailbox ports. Every port holds two separate registers, one for each direction. The host fills its outbound register and the coprocessor reads it. The coprocessor fills the other register and the host reads that one. A side therefore never sees its own write when it reads the same address.

Each processor reaches the ports through its own four-address window. The host window starts at 0x2140. The coprocessor window starts at 0xF4. Port n sits at base plus n on both buses.

Both processors run on one clock. Read data comes back from a register one cycle after the request, and a valid flag marks it. Accesses that fall outside a window change no register and return no data.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, all eight registers hold 0x00, and both read-valid outputs are low with zero read data.
- R2: The host decodes 0x2140 to 0x2143 as ports 0 to 3, where port = address − 0x2140.
- R3: The coprocessor decodes 0xF4 to 0xF7 as ports 0 to 3, where port = address − 0xF4.
- R4: A host write of value v to port n makes a later coprocessor read at 0xF4+n return v.
- R5: A coprocessor write of value v to 0xF4+n makes a later host read of port n return v.
- R6: A host read of port n returns the coprocessor-written register, not the value the host wrote. The same holds the other way round.
- R7: A read inside a window drives rvalid high with the data in the cycle after the request, for exactly one cycle.
- R8: When one side writes a port and the other side reads that port in the same cycle, the read returns the value held before the write. When both sides write the same port in one cycle, both values are kept.
- R9: A write outside a window changes no register. A read outside a window leaves rvalid low.
- R10: While rvalid is low, the matching read data output is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_addr | input | 16 | Host bus address |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data (zero unless valid) |
| h_rvalid | output | 1 | Host read data valid |
| c_addr | input | 16 | Coprocessor bus address |
| c_wr | input | 1 | Coprocessor write strobe |
| c_rd | input | 1 | Coprocessor read strobe |
| c_wdata | input | 8 | Coprocessor write data |
| c_rdata | output | 8 | Coprocessor read data (zero unless valid) |
| c_rvalid | output | 1 | Coprocessor read data valid |

## Verification
Read data and rvalid appear one clock edge after the request. A write is stored at the edge where it is presented, so a read by the other side in the next cycle returns it. A read in the same cycle as the write still returns the old value.

The bench drives each request on a falling edge. At the following rising edge, it updates a reference model of both register banks, taking the expected read values before applying the writes. It then compares the outputs on the next falling edge.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // True when address a falls inside the n-entry window starting at base.
  function automatic logic win_hit(input logic [31:0] a, input logic [31:0] base,
                                   input int unsigned n);
    return (a >= base) && (a < base + n);
  endfunction

  // Offset of address a from the window base.
  function automatic logic [31:0] win_off(input logic [31:0] a, input logic [31:0] base);
    return a - base;
  endfunction
endpackage

// File: rtl/mbx_window_dec.sv
module mbx_window_dec #(
  parameter int unsigned AW   = 16,
  parameter logic [AW-1:0] BASE = '0,
  parameter int unsigned N    = 4,
  localparam int unsigned IW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  output logic          wr_hit,
  output logic          rd_hit,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  wr_sel
);
  import mbx_pkg::*;

  logic in_win;
  assign in_win = win_hit(32'(addr), 32'(BASE), N);
  assign idx    = IW'(win_off(32'(addr), 32'(BASE)));
  assign wr_hit = wr && in_win;
  assign rd_hit = rd && in_win;

  for (genvar g = 0; g < N; g++) begin : g_sel
    assign wr_sel[g] = wr_hit && (idx == IW'(g));
  end
endmodule

// File: rtl/mbx_reg_bank.sv
module mbx_reg_bank #(
  parameter int unsigned N  = 4,
  parameter int unsigned DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    wr_sel,
  input  logic [DW-1:0]   wdata,
  output logic [N*DW-1:0] q
);
  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)         q[g*DW +: DW] <= '0;
      else if (wr_sel[g]) q[g*DW +: DW] <= wdata;
    end
  end
endmodule

// File: rtl/mbx_read_port.sv
module mbx_read_port #(
  parameter int unsigned N  = 4,
  parameter int unsigned DW = 8,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_hit,
  input  logic [IW-1:0]   idx,
  input  logic [N*DW-1:0] regs,
  output logic [DW-1:0]   rdata,
  output logic            rvalid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_hit;
      rdata  <= rd_hit ? regs[idx*DW +: DW] : '0;
    end
  end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
  parameter int unsigned NPORT     = 4,
  parameter int unsigned DW        = 8,
  parameter int unsigned HAW       = 16,
  parameter int unsigned CAW       = 16,
  parameter logic [HAW-1:0] H_BASE = 16'h2140,
  parameter logic [CAW-1:0] C_BASE = 16'h00F4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [HAW-1:0] h_addr,
  input  logic           h_wr,
  input  logic           h_rd,
  input  logic [DW-1:0]  h_wdata,
  output logic [DW-1:0]  h_rdata,
  output logic           h_rvalid,
  input  logic [CAW-1:0] c_addr,
  input  logic           c_wr,
  input  logic           c_rd,
  input  logic [DW-1:0]  c_wdata,
  output logic [DW-1:0]  c_rdata,
  output logic           c_rvalid
);
  localparam int unsigned IW = (NPORT > 1) ? $clog2(NPORT) : 1;

  // Named decode events, also observed by the checker.
  logic             h_wr_hit, h_rd_hit, c_wr_hit, c_rd_hit;
  logic [IW-1:0]    h_idx, c_idx;
  logic [NPORT-1:0] h_sel, c_sel;
  logic [NPORT*DW-1:0] h2c_q, c2h_q;

  mbx_window_dec #(.AW(HAW), .BASE(H_BASE), .N(NPORT)) u_hdec (
    .addr(h_addr), .wr(h_wr), .rd(h_rd),
    .wr_hit(h_wr_hit), .rd_hit(h_rd_hit), .idx(h_idx), .wr_sel(h_sel));

  mbx_window_dec #(.AW(CAW), .BASE(C_BASE), .N(NPORT)) u_cdec (
    .addr(c_addr), .wr(c_wr), .rd(c_rd),
    .wr_hit(c_wr_hit), .rd_hit(c_rd_hit), .idx(c_idx), .wr_sel(c_sel));

  // Host-to-coprocessor registers: written by host, read by coprocessor.
  mbx_reg_bank #(.N(NPORT), .DW(DW)) u_h2c (
    .clk(clk), .rst_n(rst_n), .wr_sel(h_sel), .wdata(h_wdata), .q(h2c_q));

  // Coprocessor-to-host registers: written by coprocessor, read by host.
  mbx_reg_bank #(.N(NPORT), .DW(DW)) u_c2h (
    .clk(clk), .rst_n(rst_n), .wr_sel(c_sel), .wdata(c_wdata), .q(c2h_q));

  mbx_read_port #(.N(NPORT), .DW(DW)) u_hrd (
    .clk(clk), .rst_n(rst_n), .rd_hit(h_rd_hit), .idx(h_idx), .regs(c2h_q),
    .rdata(h_rdata), .rvalid(h_rvalid));

  mbx_read_port #(.N(NPORT), .DW(DW)) u_crd (
    .clk(clk), .rst_n(rst_n), .rd_hit(c_rd_hit), .idx(c_idx), .regs(h2c_q),
    .rdata(c_rdata), .rvalid(c_rvalid));
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter int unsigned DW = 8,
  parameter int unsigned IW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] h_wdata,
  input logic [DW-1:0] c_wdata,
  input logic [DW-1:0] h_rdata,
  input logic [DW-1:0] c_rdata,
  input logic          h_rvalid,
  input logic          c_rvalid,
  input logic          h_wr_hit,
  input logic          h_rd_hit,
  input logic          c_wr_hit,
  input logic          c_rd_hit,
  input logic [IW-1:0] h_idx,
  input logic [IW-1:0] c_idx
);
  assert_h_read_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    h_rd_hit |=> h_rvalid);
  assert_c_read_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    c_rd_hit |=> c_rvalid);
  assert_h_miss_no_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !h_rd_hit |=> !h_rvalid);
  assert_c_miss_no_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !c_rd_hit |=> !c_rvalid);
  assert_h_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !h_rvalid |-> h_rdata == '0);
  assert_c_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !c_rvalid |-> c_rdata == '0);
  // Host write followed by a coprocessor read of that port delivers the byte.
  assert_h2c_forward_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rd_hit && $past(h_wr_hit) && c_idx == $past(h_idx)) |=> c_rdata == $past(h_wdata, 2));
  assert_c2h_forward_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rd_hit && $past(c_wr_hit) && h_idx == $past(c_idx)) |=> h_rdata == $past(c_wdata, 2));
endmodule

bind ipc_mailbox mbx_checker #(.DW(DW), .IW(IW)) u_chk (.*);

// File: tb/ipc_mailbox_tb.sv
module ipc_mailbox_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] h_addr = '0, c_addr = '0;
  logic        h_wr = 1'b0, h_rd = 1'b0, c_wr = 1'b0, c_rd = 1'b0;
  logic [7:0]  h_wdata = '0, c_wdata = '0;
  logic [7:0]  h_rdata, c_rdata;
  logic        h_rvalid, c_rvalid;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] m_h2c [4];
  logic [7:0] m_c2h [4];

  always #2 clk = ~clk;  // 250 MHz

  ipc_mailbox u_dut (.*);

  function automatic bit host_in(input logic [15:0] a);
    return a >= 16'h2140 && a <= 16'h2143;
  endfunction
  function automatic bit cop_in(input logic [15:0] a);
    return a >= 16'h00F4 && a <= 16'h00F7;
  endfunction

  task automatic check(input string tag, input string what, input logic [7:0] act,
                       input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // One bus cycle on both sides; called at a falling edge.
  task automatic step(input string tag,
                      input logic [15:0] ha, input logic hw, input logic hr, input logic [7:0] hd,
                      input logic [15:0] ca, input logic cw, input logic cr, input logic [7:0] cd);
    logic       ehv, ecv;
    logic [7:0] ehd, ecd;
    h_addr = ha; h_wr = hw; h_rd = hr; h_wdata = hd;
    c_addr = ca; c_wr = cw; c_rd = cr; c_wdata = cd;
    @(posedge clk);
    ehv = hr && host_in(ha);
    ecv = cr && cop_in(ca);
    ehd = ehv ? m_c2h[ha - 16'h2140] : 8'h00;  // reads see pre-write values
    ecd = ecv ? m_h2c[ca - 16'h00F4] : 8'h00;
    if (hw && host_in(ha)) m_h2c[ha - 16'h2140] = hd;
    if (cw && cop_in(ca))  m_c2h[ca - 16'h00F4] = cd;
    @(negedge clk);
    check(ehv ? tag : "R9", "host rvalid", {7'd0, h_rvalid}, {7'd0, ehv});
    check(ehv ? tag : "R10", "host rdata", h_rdata, ehd);
    check(ecv ? tag : "R9", "cop rvalid", {7'd0, c_rvalid}, {7'd0, ecv});
    check(ecv ? tag : "R10", "cop rdata", c_rdata, ecd);
    h_wr = 1'b0; h_rd = 1'b0; c_wr = 1'b0; c_rd = 1'b0;
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < 4; i++)
      step(tag, 16'h2140 + 16'(i), 1'b0, 1'b1, 8'h00, 16'h00F4 + 16'(i), 1'b0, 1'b1, 8'h00);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) begin
      m_h2c[i] = '0;
      m_c2h[i] = '0;
    end
    repeat (3) @(negedge clk);
    check("R1", "reset host rvalid", {7'd0, h_rvalid}, 8'h00);
    check("R1", "reset cop rvalid", {7'd0, c_rvalid}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    read_all("R1");

    // R2/R3/R4/R5: each port in both directions, read back by the other side.
    for (int i = 0; i < 4; i++)
      step("R4", 16'h2140 + 16'(i), 1'b1, 1'b0, 8'hA0 + 8'(i),
           16'h00F4 + 16'(i), 1'b1, 1'b0, 8'h50 + 8'(i));
    read_all("R2");
    read_all("R3");
    read_all("R5");

    // R6: host writes port 0, then reads it and gets the coprocessor byte.
    step("R6", 16'h2140, 1'b1, 1'b0, 8'h3C, 16'h0000, 1'b0, 1'b0, 8'h00);
    step("R6", 16'h2140, 1'b0, 1'b1, 8'h00, 16'h00F4, 1'b1, 1'b1, 8'hC3);
    step("R6", 16'h2140, 1'b0, 1'b1, 8'h00, 16'h00F4, 1'b0, 1'b1, 8'h00);

    // R8: write and cross read of the same port in one cycle, then both write.
    step("R8", 16'h2142, 1'b1, 1'b0, 8'h77, 16'h00F6, 1'b0, 1'b1, 8'h00);
    step("R8", 16'h2142, 1'b0, 1'b0, 8'h00, 16'h00F6, 1'b0, 1'b1, 8'h00);
    step("R8", 16'h2141, 1'b1, 1'b0, 8'h11, 16'h00F5, 1'b1, 1'b0, 8'h22);
    read_all("R8");

    // R9: writes just outside each window, then confirm nothing changed.
    step("R9", 16'h213F, 1'b1, 1'b1, 8'hEE, 16'h00F3, 1'b1, 1'b1, 8'hEE);
    step("R9", 16'h2144, 1'b1, 1'b1, 8'hDD, 16'h00F8, 1'b1, 1'b1, 8'hDD);
    step("R9", 16'h0140, 1'b1, 1'b1, 8'hCC, 16'h01F4, 1'b1, 1'b1, 8'hCC);
    read_all("R9");

    // R7: random traffic mixing in-window and near-window addresses.
    for (int k = 0; k < 3000; k++) begin
      logic [15:0] ha, ca;
      ha = ($urandom % 4 != 0) ? 16'h2140 + 16'($urandom % 4) : 16'h213C + 16'($urandom % 12);
      ca = ($urandom % 4 != 0) ? 16'h00F4 + 16'($urandom % 4) : 16'h00F0 + 16'($urandom % 12);
      step("R7", ha, 1'($urandom), 1'($urandom), 8'($urandom),
           ca, 1'($urandom), 1'($urandom), 8'($urandom));
    end
    read_all("R7");
    summary();
  end
endmodule